// File: doc/BRIEF.md
# Two-Sector Quota Replacement Selector

This block picks the line to evict in a set-associative cache whose lines are divided into two sectors. Sector 0 is the default and serves instruction fetch and ordinary data loads and stores. Sector 1 holds only data accesses that software has explicitly tagged. Each line keeps a sector bit. A configuration input gives the number of ways in one set that sector 1 may occupy. The remaining ways belong to sector 0.

On a miss the block receives the requester's sector, the valid bits of the addressed set and the configured limit. It answers in the same cycle with the way to refill. At the clock edge it records the requester's sector in that way and makes the way the youngest. On a hit it only refreshes the age of the way that was hit. Age is stored per set as a complete ordering of all ways, with one rank per way: rank 0 is the youngest and rank NUM_WAYS-1 the oldest. Tag compare, data storage, coherency and memory refill are handled outside this block.

Top module: `sector_victim_sel`

## Requirements
- R1: After reset every set has all sector bits at 0 and way w at rank w. On a miss to a fully valid set with sector 0 and limit 10, the victim is way NUM_WAYS-1.
- R2: When any bit of valid_i is 0, the victim is the lowest-indexed invalid way, whatever its sector.
- R3: In a fully valid set, when the requester's sector already holds at least its quota of ways, the victim is the oldest way of the requester's sector. The sector 1 quota is the limit. The sector 0 quota is NUM_WAYS minus the limit.
- R4: In a fully valid set, when the requester's sector holds fewer ways than its quota, the victim is the oldest way of the other sector.
- R5: When the sector chosen under R3 or R4 owns no way in the set, the victim is the oldest way of the whole set.
- R6: A limit value above NUM_WAYS (11 to 15) acts exactly like NUM_WAYS.
- R7: After a miss, the victim way holds the requester's sector (req_sec_i, 0 = default, 1 = tagged) and is the youngest way of its set. Every way that was younger than it ages by one.
- R8: A hit makes the hit way the youngest in the same way as R7 but leaves every sector bit unchanged.
- R9: vic_vld_o is 1 exactly when req_i is 1 and req_hit_i is 0. A cycle with req_i at 0 changes no state.
- R10: An access updates only the set named by req_set_i. Other sets keep their ages and sectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lim_i | input | LIM_W | Ways of a set allowed to sector 1; values above NUM_WAYS saturate |
| req_i | input | 1 | Access to the cache this cycle |
| req_hit_i | input | 1 | The access hit (1) or missed (0) |
| req_set_i | input | SET_W | Set index of the access |
| req_way_i | input | WAY_W | Way that hit; used only when req_hit_i is 1 |
| req_sec_i | input | 1 | Requester's sector: 0 default, 1 tagged |
| valid_i | input | NUM_WAYS | Valid bits of the addressed set |
| vic_vld_o | output | 1 | A victim is being chosen (miss) |
| vic_way_o | output | WAY_W | Way to refill |

## Verification
The bench builds the block with the default 10 ways and only 4 sets. With so few sets, random accesses keep landing on the same sets, which drives their sector mix across the quota boundary in both directions and reaches the empty-sector fallback. Random limit values include 11 to 15, and random valid masks include partly invalid sets. Directed sequences on fresh sets isolate the reset ordering, the saturated limit, and a hit that must not change a tagged line's sector.

// File: rtl/svs_pkg.sv
package svs_pkg;
  typedef enum logic {
    SEC_DEF  = 1'b0,
    SEC_MARK = 1'b1
  } sector_e;
endpackage

// File: rtl/svs_quota_ctl.sv
// Picks the sector to evict from and returns its way mask (all ways if empty).
module svs_quota_ctl
  import svs_pkg::*;
#(
  parameter int NUM_WAYS = 10,
  parameter int LIM_W    = 4
) (
  input  logic [NUM_WAYS-1:0] sec_i,
  input  logic [LIM_W-1:0]    lim_i,
  input  logic                req_sec_i,
  output logic [NUM_WAYS-1:0] mask_o
);
  localparam int CNT_W = $clog2(NUM_WAYS + 1);
  localparam int W     = (LIM_W > CNT_W) ? LIM_W : CNT_W;

  logic [W-1:0] lim_ext, q1, q0, cnt1, cnt0;
  logic         own_full;
  sector_e      req_sec, pick_sec;
  logic [NUM_WAYS-1:0] sel;

  always_comb begin
    req_sec  = sector_e'(req_sec_i);
    lim_ext  = W'(lim_i);
    q1       = (lim_ext > W'(NUM_WAYS)) ? W'(NUM_WAYS) : lim_ext;
    q0       = W'(NUM_WAYS) - q1;
    cnt1     = W'($countones(sec_i));
    cnt0     = W'(NUM_WAYS) - cnt1;
    own_full = (req_sec == SEC_MARK) ? (cnt1 >= q1) : (cnt0 >= q0);
    pick_sec = own_full ? req_sec : sector_e'(~req_sec_i);
    sel      = (pick_sec == SEC_MARK) ? sec_i : ~sec_i;
    mask_o   = (sel == '0) ? '1 : sel;
  end
endmodule

// File: rtl/svs_oldest.sv
module svs_oldest #(
  parameter int NUM_WAYS = 10,
  parameter int WAY_W    = 4,
  parameter int RANK_W   = 4
) (
  input  logic [NUM_WAYS-1:0][RANK_W-1:0] rank_i,
  input  logic [NUM_WAYS-1:0]             mask_i,
  output logic [WAY_W-1:0]                way_o
);
  logic [RANK_W-1:0] best;
  logic              found;

  always_comb begin
    way_o = '0;
    best  = '0;
    found = 1'b0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (mask_i[w] && (!found || rank_i[w] > best)) begin
        way_o = WAY_W'(w);
        best  = rank_i[w];
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/svs_age_upd.sv
// Moves the touched way to rank 0; ways younger than it age by one.
module svs_age_upd #(
  parameter int NUM_WAYS = 10,
  parameter int WAY_W    = 4,
  parameter int RANK_W   = 4
) (
  input  logic [NUM_WAYS-1:0][RANK_W-1:0] rank_i,
  input  logic [WAY_W-1:0]                touch_i,
  output logic [NUM_WAYS-1:0][RANK_W-1:0] rank_o
);
  logic [RANK_W-1:0] t_rank;

  always_comb begin
    t_rank = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (touch_i == WAY_W'(w)) t_rank = rank_i[w];
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (touch_i == WAY_W'(w))    rank_o[w] = '0;
      else if (rank_i[w] < t_rank) rank_o[w] = rank_i[w] + RANK_W'(1);
      else                         rank_o[w] = rank_i[w];
    end
  end
endmodule

// File: rtl/sector_victim_sel.sv
module sector_victim_sel #(
  parameter int NUM_WAYS = 10,
  parameter int NUM_SETS = 16,
  parameter int LIM_W    = 4,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int RANK_W  = WAY_W,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LIM_W-1:0]    lim_i,
  input  logic                req_i,
  input  logic                req_hit_i,
  input  logic [SET_W-1:0]    req_set_i,
  input  logic [WAY_W-1:0]    req_way_i,
  input  logic                req_sec_i,
  input  logic [NUM_WAYS-1:0] valid_i,
  output logic                vic_vld_o,
  output logic [WAY_W-1:0]    vic_way_o
);
  logic [NUM_SETS-1:0][NUM_WAYS-1:0][RANK_W-1:0] rank_q;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0]             sec_q;

  logic [NUM_WAYS-1:0][RANK_W-1:0] cur_rank, nxt_rank;
  logic [NUM_WAYS-1:0]             cur_sec, old_mask;
  logic [WAY_W-1:0]                old_way, inv_way, touch_way;
  logic                            has_inv, miss;

  assign cur_rank = rank_q[req_set_i];
  assign cur_sec  = sec_q[req_set_i];

  svs_quota_ctl #(.NUM_WAYS(NUM_WAYS), .LIM_W(LIM_W)) u_quota (
    .sec_i     (cur_sec),
    .lim_i     (lim_i),
    .req_sec_i (req_sec_i),
    .mask_o    (old_mask)
  );

  svs_oldest #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W), .RANK_W(RANK_W)) u_oldest (
    .rank_i (cur_rank),
    .mask_i (old_mask),
    .way_o  (old_way)
  );

  always_comb begin
    inv_way = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (!valid_i[w]) inv_way = WAY_W'(w);
  end

  assign has_inv   = ~&valid_i;
  assign miss      = req_i & ~req_hit_i;
  assign vic_vld_o = miss;
  assign vic_way_o = has_inv ? inv_way : old_way;
  assign touch_way = miss ? vic_way_o : req_way_i;

  svs_age_upd #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W), .RANK_W(RANK_W)) u_age (
    .rank_i  (cur_rank),
    .touch_i (touch_way),
    .rank_o  (nxt_rank)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          rank_q[s][w] <= RANK_W'(w);
    end else if (req_i) begin
      rank_q[req_set_i] <= nxt_rank;
      if (miss) sec_q[req_set_i][vic_way_o] <= req_sec_i;
    end
  end
endmodule

// File: rtl/svs_chk.sv
module svs_chk #(
  parameter int NUM_WAYS = 10,
  parameter int NUM_SETS = 16,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int RANK_W  = WAY_W,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                req_hit_i,
  input logic [SET_W-1:0]    req_set_i,
  input logic                req_sec_i,
  input logic [NUM_WAYS-1:0] valid_i,
  input logic                vic_vld_o,
  input logic [WAY_W-1:0]    vic_way_o,
  input logic [NUM_SETS-1:0][NUM_WAYS-1:0][RANK_W-1:0] rank_q,
  input logic [NUM_SETS-1:0][NUM_WAYS-1:0]             sec_q
);
  logic             p_miss, p_sec;
  logic [SET_W-1:0] p_set;
  logic [WAY_W-1:0] p_way;
  logic [2**RANK_W-1:0] seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_miss <= 1'b0;
      p_sec  <= 1'b0;
      p_set  <= '0;
      p_way  <= '0;
    end else begin
      p_miss <= vic_vld_o;
      p_sec  <= req_sec_i;
      p_set  <= req_set_i;
      p_way  <= vic_way_o;
    end
  end

  always_comb begin
    seen = '0;
    for (int w = 0; w < NUM_WAYS; w++) seen[rank_q[req_set_i][w]] = 1'b1;
  end

  AST_RANK_PERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(seen[NUM_WAYS-1:0]) == NUM_WAYS); // R1
  AST_INV_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vic_vld_o && (valid_i != '1) |-> !valid_i[vic_way_o]); // R2
  AST_WAY_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vic_vld_o |-> (int'(vic_way_o) < NUM_WAYS)); // R3
  AST_REFILL_YOUNG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_miss |-> rank_q[p_set][p_way] == '0); // R7
  AST_REFILL_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_miss |-> sec_q[p_set][p_way] == p_sec); // R7
  AST_HIT_KEEP_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && req_hit_i |=> $stable(sec_q)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(rank_q) && $stable(sec_q)); // R9
endmodule

bind sector_victim_sel svs_chk #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_chk (.*);

// File: tb/sim_sector_victim_sel.sv
`timescale 1ns/1ps
module sim_sector_victim_sel;
  localparam int NW = 10;
  localparam int NS = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] lim_i = '0;
  logic       req_i = 1'b0, req_hit_i = 1'b0, req_sec_i = 1'b0;
  logic [1:0] req_set_i = '0;
  logic [3:0] req_way_i = '0;
  logic [NW-1:0] valid_i = '1;
  logic       vic_vld_o;
  logic [3:0] vic_way_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  int m_rank[NS][NW];
  bit m_sec[NS][NW];

  always #2 clk_i = ~clk_i;

  sector_victim_sel #(.NUM_WAYS(NW), .NUM_SETS(NS), .LIM_W(4)) u0 (.*);

  function automatic int exp_vic(int s, bit [NW-1:0] v, int lim, bit rs, output string tag);
    int q1, q0, c1, c0, best;
    bit own, ps;
    for (int w = 0; w < NW; w++) if (!v[w]) begin tag = "R2"; return w; end
    q1 = (lim > NW) ? NW : lim;
    q0 = NW - q1;
    c1 = 0;
    for (int w = 0; w < NW; w++) c1 += int'(m_sec[s][w]);
    c0 = NW - c1;
    own = rs ? (c1 >= q1) : (c0 >= q0);
    ps  = own ? rs : !rs;
    tag = own ? "R3" : "R4";
    best = -1;
    for (int w = 0; w < NW; w++)
      if (m_sec[s][w] == ps && (best < 0 || m_rank[s][w] > m_rank[s][best])) best = w;
    if (best < 0) begin
      tag = "R5";
      for (int w = 0; w < NW; w++)
        if (best < 0 || m_rank[s][w] > m_rank[s][best]) best = w;
    end
    if (lim > NW) tag = {tag, "/R6"};
    return best;
  endfunction

  function automatic void touch(int s, int t);
    int rt = m_rank[s][t];
    for (int w = 0; w < NW; w++) if (m_rank[s][w] < rt) m_rank[s][w]++;
    m_rank[s][t] = 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic access(bit rq, bit hit, int s, int way, bit sec, int lim, bit [NW-1:0] v);
    int ev;
    string tag;
    @(negedge clk_i);
    req_i = rq; req_hit_i = hit; req_set_i = 2'(s); req_way_i = 4'(way);
    req_sec_i = sec; lim_i = 4'(lim); valid_i = v;
    #1;
    chk(vic_vld_o == (rq && !hit), "R9 vic_vld_o", int'(vic_vld_o), int'(rq && !hit));
    if (rq && !hit) begin
      ev = exp_vic(s, v, lim, sec, tag);
      chk(int'(vic_way_o) == ev, {tag, "/R7/R10 victim"}, int'(vic_way_o), ev);
      touch(s, ev);
      m_sec[s][ev] = sec;
    end else if (rq) begin
      touch(s, way);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin m_rank[s][w] = w; m_sec[s][w] = 0; end
    repeat (3) @(posedge clk_i);
    rst_ni = 1'b1;
    // R1: reset ordering
    access(0, 0, 0, 0, 0, 10, '1);
    access(1, 0, 0, 0, 0, 10, '1);
    chk(vic_way_o == 4'd9, "R1 reset victim", int'(vic_way_o), 9);
    // R2: lowest invalid way
    access(1, 0, 1, 0, 1, 3, 10'b1101110111);
    // R5: sector-1 quota of 0, no sector-1 lines
    access(1, 0, 2, 0, 1, 0, '1);
    // R4 then R6: saturated limit
    access(1, 0, 3, 0, 1, 10, '1);
    access(1, 0, 3, 0, 0, 15, '1);
    chk(vic_way_o == 4'd8, "R6 saturated limit", int'(vic_way_o), 8);
    // R8: hit on the tagged line keeps its sector
    access(1, 1, 3, 9, 0, 10, '1);
    access(1, 0, 3, 0, 1, 1, '1);
    chk(vic_way_o == 4'd9, "R8 sector kept on hit", int'(vic_way_o), 9);
    // R3/R4 fill-up on set 1
    for (int i = 0; i < 6; i++) access(1, 0, 1, 0, 1, 3, '1);
    // random mix
    void'($urandom(32'h5EC7));
    for (int i = 0; i < 4000; i++) begin
      bit [NW-1:0] v;
      v = ($urandom % 8 == 0) ? NW'($urandom) : '1;
      access(($urandom % 5) != 0, ($urandom % 5) < 2, int'($urandom % NS),
             int'($urandom % NW), 1'($urandom), int'($urandom % 16), v);
    end
    access(0, 0, 0, 0, 0, 0, '1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule